// File: doc/BRIEF.md
# Serial Port Clock Generator and Router

This block derives a serial bit clock from a fast functional clock and decides where the receive and transmit serial clocks come from. A chain of three programmable divide stages produces the generated clock. The chain runs only while the generator enable is high. When sync is enabled, a rising edge on the receive frame-sync input restarts the chain, so the generated clock lines up with that edge.

Each direction has a clock-mode input. When a mode bit is high, that direction's clock pin becomes an output and carries an internal clock. When it is low, the pin is an input and supplies the internal clock. A loopback control feeds the transmit clock into the receive side. A two-bit clock-stop field can select a master mode for serial peripheral interface (SPI) operation. In that mode the transmit clock also clocks the receiver.

All divide and mode controls are plain inputs, held static by the surrounding port logic. The routed clocks are combinational functions of the registered generated clock and the pin inputs.

Top module: `sclk_router`

## Requirements
- R1: Stage one pulses `stage1_tick` for one cycle each time its count reaches `div_a`, so the pulses repeat every `div_a`+1 cycles. Stage two pulses `stage2_tick` when stage one pulses and its own count equals `div_b`. With the generator enabled at edge 1, the stage one pulse is visible after edge `div_a` and stage two after edge (`div_b`+1)(`div_a`+1)-1.
- R2: `gen_clk` toggles every H = (`div_a`+1)(`div_b`+1)(`div_c`+1) cycles. Its first rising edge comes on the H-th clock edge after `gen_en` rises.
- R3: While `gen_en` is 0, the counters are held at zero, `gen_clk` is held low and the stage pulses stay low.
- R4: With `sync_en` = 1, a rising edge of `fs_in` is passed through two synchroniser flops. Two edges after the edge that samples it, the chain restarts: `gen_clk` is forced low and then rises H edges later.
- R5: With `sync_en` = 0, edges on `fs_in` have no effect on the `gen_clk` waveform.
- R6: With `rx_mode` = 1 and `loopback` = 0, `rx_pin_oe` = 1, and both `rx_pin_out` and `rx_clk_int` equal `gen_clk`.
- R7: With `loopback` = 1, `rx_clk_int` equals `tx_clk_int` and `rx_pin_in` is ignored. When `rx_mode` = 1 as well, `rx_pin_out` carries `tx_clk_int`.
- R8: With `tx_mode` = 1, `tx_pin_oe` = 1, and both `tx_pin_out` and `tx_clk_int` equal `gen_clk`, for every value of `clk_stop`.
- R9: With `tx_mode` = 1 and `clk_stop[1]` = 1 (codes 10 and 11), the block is an SPI master: `rx_clk_int` equals `tx_clk_int` and `rx_pin_in` is ignored. Codes 00 and 01, or `tx_mode` = 0, leave the receive routing unchanged.
- R10: A clock-mode bit of 0 deasserts that pin's output enable, and that direction's internal clock comes from its pin.
- R11: While `rst_n` is low, both output enables are 0 and `gen_clk` is 0, whatever the mode inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low reset |
| gen_en | input | 1 | Generator enable |
| sync_en | input | 1 | Frame-sync restart enable |
| fs_in | input | 1 | Receive frame-sync, asynchronous |
| div_a | input | DW | Stage one divide value, divides by value+1 |
| div_b | input | DW | Stage two divide value |
| div_c | input | DW | Stage three divide value |
| rx_mode | input | 1 | Receive clock pin is output when 1 |
| tx_mode | input | 1 | Transmit clock pin is output when 1 |
| loopback | input | 1 | Digital loopback select |
| clk_stop | input | 2 | Clock-stop field, bit 1 selects SPI master |
| rx_pin_in | input | 1 | Receive clock pin input value |
| tx_pin_in | input | 1 | Transmit clock pin input value |
| gen_clk | output | 1 | Generated clock |
| stage1_tick | output | 1 | Stage one terminal-count pulse |
| stage2_tick | output | 1 | Stage two terminal-count pulse |
| rx_pin_out | output | 1 | Receive clock pin drive value |
| rx_pin_oe | output | 1 | Receive clock pin output enable |
| tx_pin_out | output | 1 | Transmit clock pin drive value |
| tx_pin_oe | output | 1 | Transmit clock pin output enable |
| rx_clk_int | output | 1 | Internal receive clock |
| tx_clk_int | output | 1 | Internal transmit clock |

## Verification
Some behaviour is checked on every cycle by assertions:
- `gen_clk` holds its value unless stage three wraps or the chain restarts.
- A restart or a disabled generator leaves `gen_clk` low.
- A stage one pulse lasts one cycle.
- Loopback and SPI master mode tie the internal receive clock to the internal transmit clock.

Other behaviour only the bench scenarios show:
- The exact edge counts to the first `gen_clk` rise and to the stage pulses.
- The synchroniser latency in front of a restart.
- That `fs_in` is ignored while sync is off.
- The full routing table across mode combinations.

// File: rtl/sclk_router.sv
`timescale 1ns/1ps
module sclk_router #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_en,
  input  logic          sync_en,
  input  logic          fs_in,
  input  logic [DW-1:0] div_a,
  input  logic [DW-1:0] div_b,
  input  logic [DW-1:0] div_c,
  input  logic          rx_mode,
  input  logic          tx_mode,
  input  logic          loopback,
  input  logic [1:0]    clk_stop,
  input  logic          rx_pin_in,
  input  logic          tx_pin_in,
  output logic          gen_clk,
  output logic          stage1_tick,
  output logic          stage2_tick,
  output logic          rx_pin_out,
  output logic          rx_pin_oe,
  output logic          tx_pin_out,
  output logic          tx_pin_oe,
  output logic          rx_clk_int,
  output logic          tx_clk_int
);

  logic [DW-1:0] cnt1, cnt2, cnt3;
  logic [2:0]    fs_q;
  logic          gen_q;

  wire t1      = (cnt1 == div_a);
  wire t2      = t1 && (cnt2 == div_b);
  wire wrap3   = t2 && (cnt3 == div_c);
  wire restart = sync_en && fs_q[1] && !fs_q[2];
  wire spi_mst = tx_mode && clk_stop[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q  <= '0;
      cnt1  <= '0;
      cnt2  <= '0;
      cnt3  <= '0;
      gen_q <= 1'b0;
    end else begin
      fs_q <= {fs_q[1:0], fs_in};
      if (!gen_en || restart) begin
        cnt1  <= '0;
        cnt2  <= '0;
        cnt3  <= '0;
        gen_q <= 1'b0;
      end else begin
        cnt1 <= t1 ? '0 : cnt1 + 1'b1;
        if (t1) cnt2 <= (cnt2 == div_b) ? '0 : cnt2 + 1'b1;
        if (t2) cnt3 <= (cnt3 == div_c) ? '0 : cnt3 + 1'b1;
        if (wrap3) gen_q <= ~gen_q;
      end
    end
  end

  assign gen_clk     = gen_q;
  assign stage1_tick = gen_en && t1;
  assign stage2_tick = gen_en && t2;

  assign tx_clk_int = tx_mode ? gen_q : tx_pin_in;
  assign rx_clk_int = (loopback || spi_mst) ? tx_clk_int : (rx_mode ? gen_q : rx_pin_in);
  assign tx_pin_out = gen_q;
  assign rx_pin_out = loopback ? tx_clk_int : gen_q;
  assign tx_pin_oe  = tx_mode && rst_n;
  assign rx_pin_oe  = rx_mode && rst_n;

  // R2
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && !restart && !wrap3) |=> (gen_clk == $past(gen_clk)));

  // R3
  gen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !gen_clk);

  // R4
  restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!gen_clk && cnt1 == '0));

  // R1
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage1_tick && div_a != '0 && gen_en && !restart) |=> !stage1_tick);

  // R7
  loop_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> (rx_clk_int == tx_clk_int));

  // R9
  spi_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && clk_stop[1]) |-> (rx_clk_int == tx_clk_int && tx_clk_int == gen_clk));

endmodule

// File: tb/sim_sclk_router.sv
`timescale 1ns/1ps
module sim_sclk_router;
  logic clk = 0, rst_n = 0;
  logic gen_en = 0, sync_en = 0, fs_in = 0;
  logic [7:0] div_a = 1, div_b = 2, div_c = 1;
  logic rx_mode = 0, tx_mode = 0, loopback = 0, rx_pin_in = 0, tx_pin_in = 0;
  logic [1:0] clk_stop = 0;
  logic gen_clk, stage1_tick, stage2_tick, rx_pin_out, rx_pin_oe, tx_pin_out, tx_pin_oe, rx_clk_int, tx_clk_int;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sclk_router u0 (.*);

  // {rx_mode,tx_mode,loopback,clk_stop[1:0],rx_pin_in,tx_pin_in} -> {rx_oe,tx_oe,rx_out,tx_out,rx_int,tx_int}, gen_clk=0
  localparam logic [12:0] VEC [12] = '{
    {7'b0000010, 6'b000010},
    {7'b0000001, 6'b000001},
    {7'b1000001, 6'b100001},
    {7'b0100010, 6'b010010},
    {7'b1010001, 6'b101011},
    {7'b0010010, 6'b000000},
    {7'b0101010, 6'b010000},
    {7'b0101110, 6'b010000},
    {7'b0100110, 6'b010010},
    {7'b0001010, 6'b000010},
    {7'b1110000, 6'b110000},
    {7'b1100011, 6'b110000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic restart_gen();
    @(negedge clk); gen_en = 0;
    @(negedge clk); gen_en = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    if (!done) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rx_mode = 1; tx_mode = 1;
    repeat (3) @(negedge clk);
    chk("R11 reset oe", {6'b0, rx_pin_oe, tx_pin_oe}, 8'h0);
    chk("R11 reset gen", {7'b0, gen_clk}, 8'h0);
    rx_mode = 0; tx_mode = 0;
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      {rx_mode, tx_mode, loopback, clk_stop, rx_pin_in, tx_pin_in} = VEC[i][12:6];
      #1;
      chk($sformatf("R6 R7 R8 R9 R10 vector %0d", i),
          {2'b0, rx_pin_oe, tx_pin_oe, rx_pin_out, tx_pin_out, rx_clk_int, tx_clk_int},
          {2'b0, VEC[i][5:0]});
      @(negedge clk);
    end
    {rx_mode, tx_mode, loopback, clk_stop, rx_pin_in, tx_pin_in} = '0;

    // R3: disabled generator
    repeat (5) @(negedge clk);
    chk("R3 idle", {5'b0, gen_clk, stage1_tick, stage2_tick}, 8'h0);

    // R1, R2, R5: A=1 B=2 C=1 -> H=12; sync off, fs pulse ignored
    restart_gen();
    for (int m = 1; m <= 24; m++) begin
      if (m == 14) fs_in = 1;
      if (m == 17) fs_in = 0;
      @(negedge clk);
      if (m == 1) chk("R1 tick1 on", {7'b0, stage1_tick}, 8'd1);
      if (m == 2) chk("R1 tick1 off", {7'b0, stage1_tick}, 8'd0);
      if (m == 3) chk("R1 tick2 off", {7'b0, stage2_tick}, 8'd0);
      if (m == 5) chk("R1 tick2 on", {7'b0, stage2_tick}, 8'd1);
      if (m == 11) chk("R2 before rise", {7'b0, gen_clk}, 8'd0);
      if (m == 12) chk("R2 rise", {7'b0, gen_clk}, 8'd1);
      if (m == 23) chk("R5 no resync high", {7'b0, gen_clk}, 8'd1);
      if (m == 24) chk("R5 no resync fall", {7'b0, gen_clk}, 8'd0);
    end

    // R6 R8 with gen_clk high
    restart_gen();
    repeat (12) @(negedge clk);
    rx_mode = 1; tx_mode = 1; rx_pin_in = 0; tx_pin_in = 0;
    #1;
    chk("R6 R8 gen high", {4'b0, rx_pin_out, tx_pin_out, rx_clk_int, tx_clk_int}, 8'h0F);
    rx_mode = 0; tx_mode = 0;

    // R4: resync while gen_clk high
    restart_gen();
    repeat (12) @(negedge clk);
    sync_en = 1; fs_in = 1;
    for (int m = 1; m <= 15; m++) begin
      @(negedge clk);
      if (m == 3) chk("R4 forced low", {7'b0, gen_clk}, 8'd0);
      if (m == 14) chk("R4 before realigned rise", {7'b0, gen_clk}, 8'd0);
      if (m == 15) chk("R4 realigned rise", {7'b0, gen_clk}, 8'd1);
    end
    fs_in = 0; sync_en = 0;

    // R3: drop enable while running
    gen_en = 0;
    repeat (2) @(negedge clk);
    chk("R3 disable", {7'b0, gen_clk}, 8'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule